// File: doc/BRIEF.md
# Interrupt Arbitration and Trap Entry Unit

This block decides, in a single clock cycle, whether a hart leaves its current instruction stream for a trap, and computes all the values that a trap entry writes. A caller presents the present privilege level, the machine and supervisor interrupt-enable bits, the pending interrupt lines, both delegation masks, both trap-vector registers and the debug state. It also pulses an interrupt-check request, an exception request, or both. One cycle later the unit presents a registered result: whether a trap is taken, its kind, the new PC, the cause word, the saved EPC and trap value, the previous-enable and previous-privilege values to store, and the new privilege level.

Interrupts are arbitrated in two levels. Undelegated lines are considered first, under the machine enable. Delegated lines are considered only when no machine candidate exists, under the supervisor enable. Among the candidates a fixed priority picks one line. Each trap is then routed to supervisor or machine level through the delegation masks, and its target PC is formed, vectored or direct. While debug mode is active, exceptions are redirected to fixed debug addresses. Outside debug mode, a breakpoint in a privilege level whose halt enable is set enters debug mode instead of trapping. The caller owns all architectural registers and commits the result fields according to the kind code.

Top module: `trap_entry`

## Requirements
- R1: All results are registered. `tr_valid` and every output are zero after reset. The result for the requests sampled at one rising edge appears right after that edge. If neither request is raised at an edge, `tr_valid` is low after it.
- R2: An undelegated pending line (`pend[i]`=1, `ideleg[i]`=0) is a machine candidate when `priv` is below machine (encoding user=0, supervisor=1, machine=3), or when `priv` is machine and `m_ie`=1. At machine level with `m_ie`=0 it is not taken.
- R3: Delegated pending lines are considered only when there is no machine candidate. They are eligible when `priv` is user, or when `priv` is supervisor and `s_ie`=1. A delegated line is never taken at machine level.
- R4: Any candidate at line index 12 or above wins, and the lowest such index is chosen. Otherwise the order is 11, 3, 7, 9, 1, 5.
- R5: An interrupt's cause word has bit XLEN-1 set and the chosen line index in its low bits. Its trap value is zero.
- R6: A trap is routed to supervisor (kind 1, new priv 1) when `priv` is user or supervisor, the code is below XLEN (exceptions) or below NIRQ (interrupts), and the matching bit of `edeleg`/`ideleg` is set. Otherwise it goes to machine (kind 0, new priv 3).
- R7: The target PC is the target level's vector register with bit 0 cleared. When bit 0 of that register is 1 and the trap is an interrupt, 4 times the line index is added. Exceptions are never vectored.
- R8: On a normal trap, `tr_pie` carries the target level's old enable (`s_ie` or `m_ie`), `tr_pp` carries `priv`, `tr_epc` carries `cur_pc`, and `tr_tval` carries `exc_tval` for exceptions.
- R9: While `dbg_cause` is nonzero, no interrupt is taken. An exception then gives kind 3 with `tr_priv` equal to `priv`. Its PC is DBG_ROM for breakpoint code 3 and DBG_TVEC for any other code. The cause, EPC, tval, pie and pp outputs are zero.
- R10: Outside debug mode, exception code 3 raised at a privilege whose halt enable (`bp_halt_m`/`bp_halt_s`/`bp_halt_u`) is set gives kind 2. It sets `tr_cause`=1, `tr_pp`=`priv`, `tr_epc`=`cur_pc`, `tr_priv`=3 and `tr_pc`=DBG_ROM. Otherwise a breakpoint traps normally.
- R11: When `exc_req` and `irq_chk` are raised together, the exception is taken and the interrupt is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_chk | input | 1 | Evaluate pending interrupts this cycle |
| exc_req | input | 1 | Exception request this cycle |
| exc_code | input | CODE_W | Exception code |
| exc_tval | input | XLEN | Exception trap value |
| cur_pc | input | XLEN | PC of the trapping instruction |
| priv | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| m_ie | input | 1 | Machine interrupt enable |
| s_ie | input | 1 | Supervisor interrupt enable |
| pend | input | NIRQ | Pending interrupt lines |
| ideleg | input | NIRQ | Interrupt delegation mask |
| edeleg | input | XLEN | Exception delegation mask |
| mtvec | input | XLEN | Machine trap vector (bit 0 = vectored) |
| stvec | input | XLEN | Supervisor trap vector (bit 0 = vectored) |
| dbg_cause | input | 3 | Debug cause; nonzero means in debug mode |
| bp_halt_m | input | 1 | Breakpoint in machine mode enters debug |
| bp_halt_s | input | 1 | Breakpoint in supervisor mode enters debug |
| bp_halt_u | input | 1 | Breakpoint in user mode enters debug |
| tr_valid | output | 1 | A trap or redirect was taken |
| tr_kind | output | 2 | 0 machine, 1 supervisor, 2 debug entry, 3 debug redirect |
| tr_pc | output | XLEN | New PC |
| tr_cause | output | XLEN | Cause word (debug cause on debug entry) |
| tr_epc | output | XLEN | PC to save |
| tr_tval | output | XLEN | Trap value to save |
| tr_pie | output | 1 | New previous-enable value |
| tr_pp | output | 2 | Previous privilege to save |
| tr_priv | output | 2 | New privilege |

## Verification
Every result field comes from one output register, so each is due exactly one rising edge after the requests and state inputs that caused it. The bench drives every input on the falling edge. It lets one rising edge capture the values and reads all outputs a few nanoseconds after that edge, before the next falling edge changes the inputs. Cases that must not trap, such as a masked interrupt or an interrupt during debug mode, are judged on `tr_valid` in that same sampling slot.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam logic [1:0] LVL_USER = 2'd0;
  localparam logic [1:0] LVL_SUPV = 2'd1;
  localparam logic [1:0] LVL_MACH = 2'd3;

  typedef enum logic [1:0] {
    TK_MACH   = 2'd0,
    TK_SUPV   = 2'd1,
    TK_DENTER = 2'd2,
    TK_DREDIR = 2'd3
  } trap_kind_e;

  localparam int unsigned POS_HI_BASE = 12;
  localparam int unsigned POS_M_EXT   = 11;
  localparam int unsigned POS_M_SOFT  = 3;
  localparam int unsigned POS_M_TIMER = 7;
  localparam int unsigned POS_S_EXT   = 9;
  localparam int unsigned POS_S_SOFT  = 1;
  localparam int unsigned POS_S_TIMER = 5;

  localparam logic [2:0] DBGC_BREAK = 3'd1;
  localparam int unsigned CODE_BREAK = 3;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned NIRQ  = 16,
  localparam int unsigned IDX_W = $clog2(NIRQ)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       priv,
  input  logic             m_ie,
  input  logic             s_ie,
  input  logic             dbg_active,
  input  logic [NIRQ-1:0]  pend,
  input  logic [NIRQ-1:0]  ideleg,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  logic            m_en, s_en;
  logic [NIRQ-1:0] cand_m, cand_s, cand, hi_mask, hi, pick;

  genvar g;
  generate
    for (g = 0; g < NIRQ; g++) begin : g_hi
      assign hi_mask[g] = (g >= POS_HI_BASE);
    end
  endgenerate

  assign m_en   = (priv != LVL_MACH) || m_ie;
  assign s_en   = (priv == LVL_USER) || ((priv == LVL_SUPV) && s_ie);
  assign cand_m = pend & ~ideleg & {NIRQ{m_en}};
  assign cand_s = pend & ideleg & {NIRQ{s_en}};
  assign cand   = dbg_active ? '0 : ((|cand_m) ? cand_m : cand_s);
  assign hi     = cand & hi_mask;

  always_comb begin
    pick = '0;
    if (|hi)                    pick = hi;
    else if (cand[POS_M_EXT])   pick[POS_M_EXT]   = 1'b1;
    else if (cand[POS_M_SOFT])  pick[POS_M_SOFT]  = 1'b1;
    else if (cand[POS_M_TIMER]) pick[POS_M_TIMER] = 1'b1;
    else if (cand[POS_S_EXT])   pick[POS_S_EXT]   = 1'b1;
    else if (cand[POS_S_SOFT])  pick[POS_S_SOFT]  = 1'b1;
    else if (cand[POS_S_TIMER]) pick[POS_S_TIMER] = 1'b1;
  end

  always_comb begin
    idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (pick[i]) idx = IDX_W'(i);
  end

  assign hit = |pick;

  // R4: the chosen line is always one that is pending
  assert_pick_pending_R4: assert property (@(posedge clk) disable iff (rst)
    hit |-> pend[idx]);
  // R9: no line is chosen in debug mode
  assert_dbg_nopick_R9: assert property (@(posedge clk) disable iff (rst)
    dbg_active |-> !hit);
endmodule

// File: rtl/trap_target.sv
module trap_target
  import trap_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned NIRQ   = 16,
  parameter int unsigned CODE_W = 6,
  localparam int unsigned IDX_W = $clog2(NIRQ),
  localparam int unsigned LX    = $clog2(XLEN)
) (
  input  logic [1:0]        priv,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] code,
  input  logic [NIRQ-1:0]   ideleg,
  input  logic [XLEN-1:0]   edeleg,
  input  logic [XLEN-1:0]   mtvec,
  input  logic [XLEN-1:0]   stvec,
  output logic              to_s,
  output logic [XLEN-1:0]   pc
);
  localparam logic [CODE_W:0] XLEN_C = (CODE_W + 1)'(XLEN);
  localparam logic [CODE_W:0] NIRQ_C = (CODE_W + 1)'(NIRQ);

  logic            dbit;
  logic [XLEN-1:0] base, off;

  always_comb begin
    if (is_irq)
      dbit = ({1'b0, code} < NIRQ_C) && ideleg[code[IDX_W-1:0]];
    else
      dbit = ({1'b0, code} < XLEN_C) && edeleg[code[LX-1:0]];
    to_s = ((priv == LVL_USER) || (priv == LVL_SUPV)) && dbit;
    base = to_s ? stvec : mtvec;
    off  = '0;
    if (base[0] && is_irq) off[CODE_W+1:0] = {code, 2'b00};
    pc = {base[XLEN-1:1], 1'b0} + off;
  end
endmodule

// File: rtl/trap_entry.sv
module trap_entry
  import trap_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter int unsigned NIRQ     = 16,
  parameter int unsigned CODE_W   = 6,
  parameter logic [31:0] DBG_ROM  = 32'h0000_0800,
  parameter logic [31:0] DBG_TVEC = 32'h0000_0808
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_chk,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [XLEN-1:0]   exc_tval,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [1:0]        priv,
  input  logic              m_ie,
  input  logic              s_ie,
  input  logic [NIRQ-1:0]   pend,
  input  logic [NIRQ-1:0]   ideleg,
  input  logic [XLEN-1:0]   edeleg,
  input  logic [XLEN-1:0]   mtvec,
  input  logic [XLEN-1:0]   stvec,
  input  logic [2:0]        dbg_cause,
  input  logic              bp_halt_m,
  input  logic              bp_halt_s,
  input  logic              bp_halt_u,
  output logic              tr_valid,
  output logic [1:0]        tr_kind,
  output logic [XLEN-1:0]   tr_pc,
  output logic [XLEN-1:0]   tr_cause,
  output logic [XLEN-1:0]   tr_epc,
  output logic [XLEN-1:0]   tr_tval,
  output logic              tr_pie,
  output logic [1:0]        tr_pp,
  output logic [1:0]        tr_priv
);
  localparam int unsigned IDX_W = $clog2(NIRQ);
  localparam logic [XLEN-1:0] ROM_A  = XLEN'(DBG_ROM);
  localparam logic [XLEN-1:0] TVEC_A = XLEN'(DBG_TVEC);

  logic              in_dbg, irq_hit, take_irq, is_brk, bp_en, to_s;
  logic [IDX_W-1:0]  irq_idx;
  logic [CODE_W-1:0] code;
  logic [XLEN-1:0]   tgt_pc;

  logic              n_valid, n_pie;
  trap_kind_e        n_kind;
  logic [XLEN-1:0]   n_pc, n_cause, n_epc, n_tval;
  logic [1:0]        n_pp, n_priv;

  assign in_dbg = (dbg_cause != 3'd0);

  irq_arbiter #(.NIRQ(NIRQ)) u_arb (
    .clk(clk), .rst(rst), .priv(priv), .m_ie(m_ie), .s_ie(s_ie),
    .dbg_active(in_dbg), .pend(pend), .ideleg(ideleg),
    .hit(irq_hit), .idx(irq_idx)
  );

  assign take_irq = irq_chk && !exc_req && irq_hit;
  assign code     = exc_req ? exc_code : CODE_W'(irq_idx);
  assign is_brk   = (exc_code == CODE_W'(CODE_BREAK));

  always_comb begin
    case (priv)
      LVL_MACH: bp_en = bp_halt_m;
      LVL_SUPV: bp_en = bp_halt_s;
      LVL_USER: bp_en = bp_halt_u;
      default:  bp_en = 1'b0;
    endcase
  end

  trap_target #(.XLEN(XLEN), .NIRQ(NIRQ), .CODE_W(CODE_W)) u_tgt (
    .priv(priv), .is_irq(take_irq), .code(code), .ideleg(ideleg),
    .edeleg(edeleg), .mtvec(mtvec), .stvec(stvec), .to_s(to_s), .pc(tgt_pc)
  );

  always_comb begin
    n_valid = exc_req || take_irq;
    n_kind  = TK_MACH;
    n_pc    = '0;
    n_cause = '0;
    n_epc   = '0;
    n_tval  = '0;
    n_pie   = 1'b0;
    n_pp    = '0;
    n_priv  = priv;
    if (exc_req && in_dbg) begin
      n_kind = TK_DREDIR;
      n_pc   = is_brk ? ROM_A : TVEC_A;
    end else if (exc_req && is_brk && bp_en) begin
      n_kind  = TK_DENTER;
      n_pc    = ROM_A;
      n_cause = XLEN'(DBGC_BREAK);
      n_epc   = cur_pc;
      n_pp    = priv;
      n_priv  = LVL_MACH;
    end else if (n_valid) begin
      n_kind  = to_s ? TK_SUPV : TK_MACH;
      n_pc    = tgt_pc;
      n_cause = XLEN'(code);
      if (take_irq) n_cause[XLEN-1] = 1'b1;
      n_epc   = cur_pc;
      n_tval  = take_irq ? '0 : exc_tval;
      n_pie   = to_s ? s_ie : m_ie;
      n_pp    = priv;
      n_priv  = to_s ? LVL_SUPV : LVL_MACH;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tr_valid <= 1'b0;
      tr_kind  <= 2'd0;
      tr_pc    <= '0;
      tr_cause <= '0;
      tr_epc   <= '0;
      tr_tval  <= '0;
      tr_pie   <= 1'b0;
      tr_pp    <= '0;
      tr_priv  <= '0;
    end else begin
      tr_valid <= n_valid;
      tr_kind  <= n_kind;
      tr_pc    <= n_pc;
      tr_cause <= n_cause;
      tr_epc   <= n_epc;
      tr_tval  <= n_tval;
      tr_pie   <= n_pie;
      tr_pp    <= n_pp;
      tr_priv  <= n_priv;
    end
  end

  // R1: no request at an edge gives no result after it
  assert_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !(irq_chk || exc_req) |=> !tr_valid);
  // R9: interrupt checks during debug mode never produce a result
  assert_dbg_noirq_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_chk && !exc_req && in_dbg) |=> !tr_valid);
  // R6: supervisor-level entry only from user or supervisor
  assert_supv_route_R6: assert property (@(posedge clk) disable iff (rst)
    (tr_valid && tr_kind == TK_SUPV) |-> ($past(priv) == LVL_USER || $past(priv) == LVL_SUPV));
  // R11: a simultaneous exception wins over an interrupt
  assert_exc_first_R11: assert property (@(posedge clk) disable iff (rst)
    (exc_req && irq_chk) |=> (tr_valid && !tr_cause[XLEN-1]));
  // R10: debug entry lands in machine mode at the debug ROM
  assert_denter_R10: assert property (@(posedge clk) disable iff (rst)
    (tr_valid && tr_kind == TK_DENTER) |-> (tr_priv == LVL_MACH && tr_pc == ROM_A));
endmodule

// File: tb/trap_entry_bench.sv
module trap_entry_bench;
  localparam int XLEN = 32;
  localparam int NIRQ = 16;
  localparam int CODE_W = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic irq_chk = 0, exc_req = 0;
  logic [CODE_W-1:0] exc_code = '0;
  logic [XLEN-1:0] exc_tval = '0, cur_pc = '0;
  logic [1:0] priv = 2'd3;
  logic m_ie = 0, s_ie = 0;
  logic [NIRQ-1:0] pend = '0, ideleg = '0;
  logic [XLEN-1:0] edeleg = '0, mtvec = 32'h1000, stvec = 32'h2001;
  logic [2:0] dbg_cause = '0;
  logic bp_halt_m = 0, bp_halt_s = 0, bp_halt_u = 0;
  logic tr_valid, tr_pie;
  logic [1:0] tr_kind, tr_pp, tr_priv;
  logic [XLEN-1:0] tr_pc, tr_cause, tr_epc, tr_tval;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_entry u_trap_entry (
    .clk(clk), .rst(rst), .irq_chk(irq_chk), .exc_req(exc_req),
    .exc_code(exc_code), .exc_tval(exc_tval), .cur_pc(cur_pc), .priv(priv),
    .m_ie(m_ie), .s_ie(s_ie), .pend(pend), .ideleg(ideleg), .edeleg(edeleg),
    .mtvec(mtvec), .stvec(stvec), .dbg_cause(dbg_cause),
    .bp_halt_m(bp_halt_m), .bp_halt_s(bp_halt_s), .bp_halt_u(bp_halt_u),
    .tr_valid(tr_valid), .tr_kind(tr_kind), .tr_pc(tr_pc), .tr_cause(tr_cause),
    .tr_epc(tr_epc), .tr_tval(tr_tval), .tr_pie(tr_pie), .tr_pp(tr_pp),
    .tr_priv(tr_priv)
  );

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive requests on the falling edge, sample 4 ns after the capturing rising edge
  task automatic fire(input logic irq, input logic exc);
    @(negedge clk);
    irq_chk = irq;
    exc_req = exc;
    @(posedge clk);
    #4;
  endtask

  task automatic expect_trap(string req, logic [1:0] kind, logic [31:0] pc,
                             logic [31:0] cause, logic [1:0] npriv);
    chk(req, "valid", 64'(tr_valid), 64'd1);
    chk(req, "kind", 64'(tr_kind), 64'(kind));
    chk(req, "pc", 64'(tr_pc), 64'(pc));
    chk(req, "cause", 64'(tr_cause), 64'(cause));
    chk(req, "priv", 64'(tr_priv), 64'(npriv));
  endtask

  task automatic t_reset;
    chk("R1", "reset valid", 64'(tr_valid), 64'd0);
    chk("R1", "reset pc", 64'(tr_pc), 64'd0);
    chk("R1", "reset priv", 64'(tr_priv), 64'd0);
    fire(1'b0, 1'b0);
    chk("R1", "idle valid", 64'(tr_valid), 64'd0);
  endtask

  task automatic t_machine_irq;
    priv = 2'd3; m_ie = 1'b0; pend = 16'h0080; ideleg = '0;
    fire(1'b1, 1'b0);
    chk("R2", "masked at M", 64'(tr_valid), 64'd0);
    priv = 2'd0; m_ie = 1'b1; cur_pc = 32'h0000_3330;
    fire(1'b1, 1'b0);
    expect_trap("R2", 2'd0, 32'h1000, 32'h8000_0007, 2'd3);
    chk("R5", "irq tval", 64'(tr_tval), 64'd0);
    chk("R8", "epc", 64'(tr_epc), 64'h3330);
    chk("R8", "pie", 64'(tr_pie), 64'd1);
    chk("R8", "pp", 64'(tr_pp), 64'd0);
    priv = 2'd3;
    fire(1'b1, 1'b0);
    expect_trap("R2", 2'd0, 32'h1000, 32'h8000_0007, 2'd3);
    chk("R8", "pp at M", 64'(tr_pp), 64'd3);
  endtask

  task automatic t_priority;
    priv = 2'd3; m_ie = 1'b1; ideleg = '0;
    pend = 16'h0AAA; fire(1'b1, 1'b0); chk("R4", "pick 11", 64'(tr_cause), 64'h8000_000B);
    pend = 16'h02AA; fire(1'b1, 1'b0); chk("R4", "pick 3", 64'(tr_cause), 64'h8000_0003);
    pend = 16'h02A2; fire(1'b1, 1'b0); chk("R4", "pick 7", 64'(tr_cause), 64'h8000_0007);
    pend = 16'h0222; fire(1'b1, 1'b0); chk("R4", "pick 9", 64'(tr_cause), 64'h8000_0009);
    pend = 16'h0022; fire(1'b1, 1'b0); chk("R4", "pick 1", 64'(tr_cause), 64'h8000_0001);
    pend = 16'h0020; fire(1'b1, 1'b0); chk("R4", "pick 5", 64'(tr_cause), 64'h8000_0005);
    pend = 16'h6800; fire(1'b1, 1'b0); chk("R4", "pick 13", 64'(tr_cause), 64'h8000_000D);
    mtvec = 32'h1001; pend = 16'h0008;
    fire(1'b1, 1'b0);
    chk("R7", "vectored M", 64'(tr_pc), 64'h100C);
    mtvec = 32'h1000;
  endtask

  task automatic t_supv_irq;
    ideleg = 16'h0222; stvec = 32'h2001; m_ie = 1'b1;
    priv = 2'd0; s_ie = 1'b0; pend = 16'h0020;
    fire(1'b1, 1'b0);
    expect_trap("R6", 2'd1, 32'h2014, 32'h8000_0005, 2'd1);
    chk("R8", "s pie", 64'(tr_pie), 64'd0);
    priv = 2'd1; s_ie = 1'b1;
    fire(1'b1, 1'b0);
    expect_trap("R3", 2'd1, 32'h2014, 32'h8000_0005, 2'd1);
    chk("R8", "s pie set", 64'(tr_pie), 64'd1);
    chk("R8", "s pp", 64'(tr_pp), 64'd1);
    s_ie = 1'b0;
    fire(1'b1, 1'b0);
    chk("R3", "S masked", 64'(tr_valid), 64'd0);
    priv = 2'd0; pend = 16'h00A0;
    fire(1'b1, 1'b0);
    expect_trap("R3", 2'd0, 32'h1000, 32'h8000_0007, 2'd3);
    priv = 2'd3; pend = 16'h0020;
    fire(1'b1, 1'b0);
    chk("R3", "delegated at M", 64'(tr_valid), 64'd0);
    ideleg = '0; pend = '0;
  endtask

  task automatic t_exceptions;
    edeleg = 32'h0000_2000; stvec = 32'h2001; mtvec = 32'h1001;
    priv = 2'd1; s_ie = 1'b1; exc_code = 6'd13;
    cur_pc = 32'h4444; exc_tval = 32'hDEAD;
    fire(1'b0, 1'b1);
    expect_trap("R6", 2'd1, 32'h2000, 32'd13, 2'd1);
    chk("R7", "no vector exc S", 64'(tr_pc), 64'h2000);
    chk("R8", "epc", 64'(tr_epc), 64'h4444);
    chk("R8", "tval", 64'(tr_tval), 64'hDEAD);
    chk("R8", "pie", 64'(tr_pie), 64'd1);
    priv = 2'd3; m_ie = 1'b0;
    fire(1'b0, 1'b1);
    expect_trap("R6", 2'd0, 32'h1000, 32'd13, 2'd3);
    chk("R8", "M pie", 64'(tr_pie), 64'd0);
    priv = 2'd0; edeleg = 32'hFFFF_FFFF; exc_code = 6'd40;
    fire(1'b0, 1'b1);
    expect_trap("R6", 2'd0, 32'h1000, 32'd40, 2'd3);
    mtvec = 32'h1000; edeleg = '0;
  endtask

  task automatic t_both;
    priv = 2'd0; m_ie = 1'b1; pend = 16'h0080; exc_code = 6'd2;
    fire(1'b1, 1'b1);
    expect_trap("R11", 2'd0, 32'h1000, 32'd2, 2'd3);
    pend = '0;
  endtask

  task automatic t_debug;
    dbg_cause = 3'd3; priv = 2'd0; pend = 16'h0080; m_ie = 1'b1;
    fire(1'b1, 1'b0);
    chk("R9", "no irq in debug", 64'(tr_valid), 64'd0);
    exc_code = 6'd3; cur_pc = 32'h7770;
    fire(1'b0, 1'b1);
    expect_trap("R9", 2'd3, 32'h0800, 32'd0, 2'd0);
    chk("R9", "epc untouched", 64'(tr_epc), 64'd0);
    exc_code = 6'd5;
    fire(1'b0, 1'b1);
    expect_trap("R9", 2'd3, 32'h0808, 32'd0, 2'd0);
    dbg_cause = '0; pend = '0;
  endtask

  task automatic t_bp_enter;
    priv = 2'd1; bp_halt_s = 1'b1; exc_code = 6'd3; cur_pc = 32'h5550; edeleg = '0;
    fire(1'b0, 1'b1);
    expect_trap("R10", 2'd2, 32'h0800, 32'd1, 2'd3);
    chk("R10", "dpc", 64'(tr_epc), 64'h5550);
    chk("R10", "saved priv", 64'(tr_pp), 64'd1);
    bp_halt_s = 1'b0; bp_halt_m = 1'b1;
    fire(1'b0, 1'b1);
    expect_trap("R10", 2'd0, 32'h1000, 32'd3, 2'd3);
    bp_halt_m = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #4;
    t_reset_pre();
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_machine_irq();
    t_priority();
    t_supv_irq();
    t_exceptions();
    t_both();
    t_debug();
    t_bp_enter();
    fire(1'b0, 1'b0);
    chk("R1", "idle after traffic", 64'(tr_valid), 64'd0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic t_reset_pre;
    chk("R1", "in reset valid", 64'(tr_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule